// File: doc/BRIEF.md
# Min/Max Sample Pair Packer

This block sits between a byte-wide sample source and an acquisition memory. Once per conversion clock it takes one sample. Consecutive samples go alternately into a minimum-slot register and a maximum-slot register. A phase toggle decides which slot is written: it has a period of two conversion clocks and spends half of that period on each slot. When a pair is complete, the two bytes are latched together into a 16-bit word. A single pulse then writes that word to memory and advances the memory address.

An active-low test input switches the sample source from the converter to an internal diagnostic counter. The counter steps on every conversion clock. The maximum slot is therefore always loaded one clock after the minimum slot, so in test mode every stored word holds a byte and that byte plus one. This gives a known memory pattern that software can check.

While acquisition is disabled, nothing is captured and no write occurs. The phase returns to the minimum slot, so the next sample after re-enabling always starts a new pair.

Top module: `minmax_packer`

## Requirements
- R1: While reset is high and on the first cycle after it, `word_out` is 0x0000 and `wr_strobe` and `addr_inc` are 0.
- R2: With `acq_en` held high from the clock edge after reset, `wr_strobe` is high for exactly one cycle in every two. The first pulse is visible after the third rising edge that samples `acq_en` high.
- R3: Each packed word carries the first sample of its pair (the minimum slot) in bits 7:0 and the second sample (the maximum slot) in bits 15:8. The word appears on `word_out` in the same cycle as the `wr_strobe` pulse that writes it.
- R4: When `test_n` is 0, the sample taken is the diagnostic counter. The counter is 0x00 after reset, increases by one on every clock edge whether or not acquisition is enabled, and wraps from 0xFF to 0x00. When `test_n` is 1, the sample taken is `adc_data`.
- R5: With `test_n` held at 0 for both samples of a pair, bits 15:8 of the written word equal bits 7:0 plus one, modulo 256.
- R6: `addr_inc` pulses in exactly the same cycles as `wr_strobe`.
- R7: A clock edge that samples `acq_en` low captures no sample, produces no write strobe in the following cycle, and returns the phase to the minimum slot. The first sample after re-enabling therefore lands in bits 7:0.
- R8: `word_out` keeps its value in every cycle without a write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_en | input | 1 | Acquisition enable; high lets samples be captured |
| test_n | input | 1 | Active-low test select; 0 takes the diagnostic counter as sample |
| adc_data | input | 8 | Converter sample byte |
| word_out | output | 16 | Packed pair: minimum slot in 7:0, maximum slot in 15:8 |
| wr_strobe | output | 1 | One-cycle memory write pulse for `word_out` |
| addr_inc | output | 1 | One-cycle address counter advance, coincident with the write |

## Verification
A phase toggle that misses a flip or a reset shows up at the ports as bytes swapped within the word, or as strobes spaced one or three cycles apart. The per-clock comparison catches either fault at the very next expected strobe, which is at most two cycles away. A diagnostic counter that does not step makes the upper byte of a test-mode word equal its lower byte, and this shows on the first test-mode write. A pending-pair flag that survives while acquisition is disabled produces an extra strobe on the cycle after the disable edge.

// File: rtl/minmax_pkg.sv
package minmax_pkg;

    typedef enum logic {
        PH_MIN = 1'b0,
        PH_MAX = 1'b1
    } phase_e;

    localparam int LANES = 2;

    function automatic phase_e next_phase(input phase_e cur);
        return (cur == PH_MIN) ? PH_MAX : PH_MIN;
    endfunction

endpackage

// File: rtl/diag_gen.sv
module diag_gen #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] pattern
);
    logic [DATA_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign pattern = cnt_q;

    // R4: counter steps by one each clock, wrapping
    a_r4_diag_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == DATA_W'($past(cnt_q) + 1'b1));

endmodule

// File: rtl/phase_seq.sv
module phase_seq
    import minmax_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    output phase_e phase
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst || !en) phase_q <= PH_MIN;
        else            phase_q <= next_phase(phase_q);
    end

    assign phase = phase_q;

    // R7: disabled edge returns the toggle to the minimum slot
    a_r7_phase_restart: assert property (@(posedge clk) disable iff (rst)
        !en |=> phase_q == PH_MIN);

    // R2: enabled toggle alternates each clock
    a_r2_phase_alt: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst)) |-> phase_q != $past(phase_q));

endmodule

// File: rtl/pair_capture.sv
module pair_capture
    import minmax_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WORD_W = LANES * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] sample,
    input  logic              sel_diag,
    output logic [WORD_W-1:0] word,
    output logic              strobe,
    output logic              addr_inc
);
    logic [DATA_W-1:0] slot_q [LANES];
    logic [DATA_W-1:0] lane_q [LANES];
    logic              pend_q;
    logic              strobe_q;
    logic              inc_q;
    logic              diag_min_q;
    logic              diag_max_q;
    logic              diag_word_q;
    logic              do_write;

    assign do_write = en && pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            strobe_q    <= 1'b0;
            inc_q       <= 1'b0;
            diag_min_q  <= 1'b0;
            diag_max_q  <= 1'b0;
            diag_word_q <= 1'b0;
        end else begin
            pend_q   <= en && (phase == PH_MAX);
            strobe_q <= do_write;
            inc_q    <= do_write;
            if (en && phase == PH_MIN) diag_min_q <= sel_diag;
            if (en && phase == PH_MAX) diag_max_q <= sel_diag;
            if (do_write) diag_word_q <= diag_min_q && diag_max_q;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
                lane_q[i] <= '0;
            end else begin
                if (en && phase == phase_e'(i)) slot_q[i] <= sample;
                if (do_write) lane_q[i] <= slot_q[i];
            end
        end
        assign word[i*DATA_W +: DATA_W] = lane_q[i];
    end

    assign strobe   = strobe_q;
    assign addr_inc = inc_q;

    // R5: test-mode word has upper byte = lower byte + 1
    a_r5_diag_pair: assert property (@(posedge clk) disable iff (rst)
        (strobe_q && diag_word_q) |->
        lane_q[1] == DATA_W'(lane_q[0] + 1'b1));

    // R6: address advance coincides with the write
    a_r6_inc_match: assert property (@(posedge clk) disable iff (rst)
        addr_inc == strobe);

endmodule

// File: rtl/minmax_packer.sv
module minmax_packer (
    input  logic        clk,
    input  logic        rst,
    input  logic        acq_en,
    input  logic        test_n,
    input  logic [7:0]  adc_data,
    output logic [15:0] word_out,
    output logic        wr_strobe,
    output logic        addr_inc
);
    import minmax_pkg::*;

    localparam int DATA_W = 8;

    logic [DATA_W-1:0] diag_val;
    logic [DATA_W-1:0] sample;
    phase_e            phase;

    diag_gen #(.DATA_W(DATA_W)) u_diag (
        .clk     (clk),
        .rst     (rst),
        .pattern (diag_val)
    );

    phase_seq u_phase (
        .clk   (clk),
        .rst   (rst),
        .en    (acq_en),
        .phase (phase)
    );

    assign sample = test_n ? adc_data : diag_val;

    pair_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .en       (acq_en),
        .phase    (phase),
        .sample   (sample),
        .sel_diag (!test_n),
        .word     (word_out),
        .strobe   (wr_strobe),
        .addr_inc (addr_inc)
    );

    // R2: never two writes back to back
    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);

    // R7: disabled edge yields no write next cycle
    a_r7_no_write_idle: assert property (@(posedge clk) disable iff (rst)
        !acq_en |=> !wr_strobe);

    // R8: word holds between writes
    a_r8_word_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_strobe && !$past(rst)) |-> $stable(word_out));

endmodule

// File: tb/minmax_packer_tb.sv
module minmax_packer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acq_en = 1'b0;
    logic        test_n = 1'b1;
    logic [7:0]  adc_data = 8'h00;
    logic [15:0] word_out;
    logic        wr_strobe;
    logic        addr_inc;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // behavioural reference state
    int m_diag = 0, m_phase = 0, m_min = 0, m_max = 0;
    int m_pend = 0, m_word = 0, m_strb = 0;

    minmax_packer u_dut (
        .clk(clk), .rst(rst), .acq_en(acq_en), .test_n(test_n),
        .adc_data(adc_data), .word_out(word_out),
        .wr_strobe(wr_strobe), .addr_inc(addr_inc)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    task automatic model_edge(input bit r, input bit en, input bit tn, input int d);
        int src;
        int nw;
        if (r) begin
            m_diag = 0; m_phase = 0; m_min = 0; m_max = 0;
            m_pend = 0; m_word = 0; m_strb = 0;
            return;
        end
        src = tn ? d : m_diag;
        nw = (m_max << 8) | m_min;
        m_strb = en && m_pend;
        if (en && m_pend) m_word = nw;
        m_pend = en && (m_phase == 1);
        if (en && m_phase == 0) m_min = src;
        if (en && m_phase == 1) m_max = src;
        m_phase = en ? 1 - m_phase : 0;
        m_diag = (m_diag + 1) % 256;
    endtask

    task automatic step(input string req, input bit r, input bit en, input bit tn, input int d);
        rst = r; acq_en = en; test_n = tn; adc_data = d[7:0];
        model_edge(r, en, tn, d);
        @(posedge clk);
        @(negedge clk);
        cyc++;
        check({req, " word"}, int'(word_out), m_word);
        check({req, " strobe"}, int'(wr_strobe), m_strb);
        check("R6 addr_inc", int'(addr_inc), int'(wr_strobe));
        if (!wr_strobe && cyc > 3) check("R8 hold", int'(word_out), m_word);
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step("R1", 1, 0, 1, 8'h5A);
        check("R1 reset word", int'(word_out), 0);
        check("R1 reset strobe", int'(wr_strobe), 0);
        step("R1", 0, 0, 1, 8'h33);
        check("R1 post reset word", int'(word_out), 0);
        check("R1 post reset inc", int'(addr_inc), 0);

        // R2/R3 directed: pair 0x11,0x22 -> 0x2211
        step("R2", 0, 1, 1, 8'h11);
        step("R2", 0, 1, 1, 8'h22);
        check("R2 no early strobe", int'(wr_strobe), 0);
        step("R2", 0, 1, 1, 8'h33);
        check("R2 first strobe", int'(wr_strobe), 1);
        check("R3 packed word", int'(word_out), 16'h2211);
        step("R2", 0, 1, 1, 8'h44);
        check("R2 gap", int'(wr_strobe), 0);
        step("R3", 0, 1, 1, 8'h55);
        check("R3 second word", int'(word_out), 16'h4433);

        // varied converter data
        for (int i = 0; i < 40; i++) step("R3", 0, 1, 1, (i * 37 + 5) % 256);

        // R7: disable mid pair, re-enable
        step("R7", 0, 1, 1, 8'hA1);
        step("R7", 0, 0, 1, 8'hB2);
        step("R7", 0, 0, 1, 8'hC3);
        check("R7 no strobe idle", int'(wr_strobe), 0);
        step("R7", 0, 1, 1, 8'hD4);
        step("R7", 0, 1, 1, 8'hE5);
        step("R7", 0, 1, 1, 8'hF6);
        check("R7 restart low byte", int'(word_out), 16'hE5D4);
        step("R7", 0, 0, 1, 8'h00);
        step("R7", 0, 0, 1, 8'h00);

        // R4/R5: test mode, long enough to wrap the counter
        for (int i = 0; i < 600; i++) begin
            step("R4", 0, 1, 0, 8'h99);
            if (wr_strobe && i > 2)
                check("R5 max=min+1", int'(word_out[15:8]), (int'(word_out[7:0]) + 1) % 256);
        end

        // toggling enable and mode
        for (int i = 0; i < 300; i++)
            step("R7", 0, (i % 7) != 3, (i % 11) < 6, (i * 13) % 256);

        step("R1", 1, 1, 1, 8'h77);
        step("R1", 0, 0, 1, 8'h77);
        check("R1 re-reset word", int'(word_out), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule